// File: doc/BRIEF.md
# Accumulator Machine Hardwired Control Sequencer

This block is the hardwired control unit of a single-accumulator processor. On a start strobe it captures a decoded opcode. It then runs a generic fetch prelude, followed by one to three numbered execute steps. In each step it drives a fixed set of register-transfer enables for the memory address register, the memory buffer register, the accumulator, the program counter and the ALU. It also drives the memory read and write strobes and a two-bit ALU function code.

Every control output is registered, so each step's enables are stable for one full clock period. After the last step a one-cycle completion pulse is raised and the unit is idle again. A new start may be given in that same cycle. An opcode with no defined meaning is refused: it raises a one-cycle illegal flag and nothing else.

Top module: `acc_ctrl_unit`

## Requirements
- R1: While rst_ni is low and in the first idle cycle after it, every output is 0 except alu_op_o, which reads 2'b11.
- R2: opcode_i codes are 0 load, 1 store, 2 add, 3 and, 4 jump, 5 jump-if-zero, 6 complement, 7 undefined. A start_i seen high at an edge while idle with a defined code makes fetch_o and busy_o high for the next FETCH_STEPS cycles. Execute step t1 follows, and busy_o stays high through the last step.
- R3: Load runs t1 mar_ld_o, then t2 mbr_from_mem_o with mem_rd_o, then t3 ac_from_mbr_o.
- R4: Store runs t1 mar_ld_o, then t2 mbr_from_ac_o, then t3 mem_from_mbr_o with mem_wr_o.
- R5: Add and bitwise-and run t1 mar_ld_o and t2 mbr_from_mem_o with mem_rd_o. In t3 they raise alu_en_o, alu_opnd_o and ac_from_alu_o, with alu_op_o 2'b00 for add and 2'b01 for and.
- R6: Jump has the single step t1, which raises pc_ld_o.
- R7: Jump-if-zero has the single step t1. It raises pc_ld_o only if ac_zero_i is high at the clock edge that enters t1; otherwise that step drives only busy_o.
- R8: Complement has the single step t1, which raises alu_en_o, alu_opnd_o and ac_from_alu_o with alu_op_o 2'b10.
- R9: alu_op_o reads 2'b11 whenever alu_en_o is low. alu_en_o never appears without both alu_opnd_o and ac_from_alu_o.
- R10: done_o is high for exactly the one cycle after the last step, with busy_o low. A start_i given in that cycle is accepted.
- R11: A start with code 7 while idle raises illegal_o for exactly one cycle. No other output goes high, and the unit stays idle.
- R12: start_i and opcode_i are ignored while busy_o is high. The running sequence continues unchanged.
- R13: mem_rd_o and mem_wr_o are never high together. The accumulator write from the ALU never shares a step with mar_ld_o or mbr_from_mem_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (sampled while idle) |
| opcode_i | input | 3 | Decoded opcode from the instruction register |
| ac_zero_i | input | 1 | Accumulator equals zero |
| fetch_o | output | 1 | Fetch prelude in progress |
| busy_o | output | 1 | Prelude or execute step active |
| mar_ld_o | output | 1 | MAR takes the instruction address field |
| mbr_from_mem_o | output | 1 | MBR takes memory read data |
| mem_rd_o | output | 1 | Memory read strobe |
| ac_from_mbr_o | output | 1 | AC takes MBR |
| mbr_from_ac_o | output | 1 | MBR takes AC |
| mem_from_mbr_o | output | 1 | Memory data bus driven from MBR |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_ld_o | output | 1 | PC takes the instruction address field |
| alu_en_o | output | 1 | ALU operation active |
| alu_opnd_o | output | 1 | Operand path into the ALU enabled |
| ac_from_alu_o | output | 1 | AC takes the ALU result |
| alu_op_o | output | 2 | ALU function: 00 add, 01 and, 10 invert, 11 pass |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle undefined-opcode pulse |

## Verification
The embedded properties assume that the enclosing datapath presents opcode_i only together with start_i. They also assume that ac_zero_i is valid at the edge that enters t1; the unit latches the opcode once, so later opcode changes do not matter. The bench drives every input on the falling clock edge, so none of them changes near a sampling edge. It holds ac_zero_i constant across each jump-if-zero run. It also deliberately toggles start_i and opcode_i during busy windows to show that they are ignored.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int unsigned OP_W   = 3;
  localparam int unsigned STEP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_AND   = 3'd3,
    OP_JMP   = 3'd4,
    OP_JZ    = 3'd5,
    OP_CMPL  = 3'd6
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_AND  = 2'b01,
    ALU_NOT  = 2'b10,
    ALU_PASS = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  typedef struct packed {
    logic    fetch;
    logic    busy;
    logic    mar_ld;
    logic    mbr_from_mem;
    logic    mem_rd;
    logic    ac_from_mbr;
    logic    mbr_from_ac;
    logic    mem_from_mbr;
    logic    mem_wr;
    logic    pc_ld;
    logic    alu_en;
    logic    alu_opnd;
    logic    ac_from_alu;
    alu_op_e alu_op;
    logic    done;
    logic    illegal;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{alu_op: ALU_PASS, default: 1'b0};

  function automatic logic op_legal(input logic [OP_W-1:0] code);
    return code <= OP_W'(OP_CMPL);
  endfunction

  // number of execute steps per instruction
  function automatic logic [STEP_W-1:0] steps_of(input opcode_e op);
    case (op)
      OP_JMP, OP_JZ, OP_CMPL: return STEP_W'(1);
      default:                return STEP_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/acc_ctrl_seq.sv
module acc_ctrl_seq
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned FETCH_STEPS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [OP_W-1:0]      opcode_i,
  output phase_e               phase_d_o,
  output logic [STEP_W-1:0]    step_d_o,
  output opcode_e              op_d_o,
  output logic                 done_d_o,
  output logic                 illegal_d_o
);

  localparam int unsigned FC_W = $clog2(FETCH_STEPS + 1);

  phase_e              phase_q, phase_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [FC_W-1:0]     fcnt_q, fcnt_d;
  opcode_e             op_q, op_d;

  always_comb begin
    phase_d     = phase_q;
    step_d      = step_q;
    fcnt_d      = fcnt_q;
    op_d        = op_q;
    done_d_o    = 1'b0;
    illegal_d_o = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (op_legal(opcode_i)) begin
            op_d    = opcode_e'(opcode_i);
            phase_d = PH_FETCH;
            fcnt_d  = FC_W'(1);
          end else begin
            illegal_d_o = 1'b1;
          end
        end
      end
      PH_FETCH: begin
        if (fcnt_q == FC_W'(FETCH_STEPS)) begin
          phase_d = PH_EXEC;
          step_d  = STEP_W'(1);
          fcnt_d  = '0;
        end else begin
          fcnt_d = fcnt_q + FC_W'(1);
        end
      end
      PH_EXEC: begin
        if (step_q == steps_of(op_q)) begin
          phase_d  = PH_IDLE;
          step_d   = '0;
          done_d_o = 1'b1;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      fcnt_q  <= '0;
      op_q    <= OP_LOAD;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      fcnt_q  <= fcnt_d;
      op_q    <= op_d;
    end
  end

  assign phase_d_o = phase_d;
  assign step_d_o  = step_d;
  assign op_d_o    = op_d;

  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC) |-> (step_q != '0 && step_q <= steps_of(op_q))); // R2

  AST_OP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_d != PH_IDLE) |=> $stable(op_q)); // R12

endmodule

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
  import acc_ctrl_pkg::*;
(
  input  phase_e            phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  opcode_e           op_i,
  input  logic              ac_zero_i,
  input  logic              done_i,
  input  logic              illegal_i,
  output ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o         = CTRL_IDLE;
    ctrl_o.done    = done_i;
    ctrl_o.illegal = illegal_i;
    ctrl_o.busy    = (phase_i != PH_IDLE);
    ctrl_o.fetch   = (phase_i == PH_FETCH);
    if (phase_i == PH_EXEC) begin
      case (op_i)
        OP_LOAD, OP_STORE, OP_ADD, OP_AND: begin
          case (step_i)
            STEP_W'(1): ctrl_o.mar_ld = 1'b1;
            STEP_W'(2): begin
              if (op_i == OP_STORE) ctrl_o.mbr_from_ac = 1'b1;
              else begin
                ctrl_o.mbr_from_mem = 1'b1;
                ctrl_o.mem_rd       = 1'b1;
              end
            end
            STEP_W'(3): begin
              case (op_i)
                OP_LOAD:  ctrl_o.ac_from_mbr = 1'b1;
                OP_STORE: begin
                  ctrl_o.mem_from_mbr = 1'b1;
                  ctrl_o.mem_wr       = 1'b1;
                end
                default: begin
                  ctrl_o.alu_en      = 1'b1;
                  ctrl_o.alu_opnd    = 1'b1;
                  ctrl_o.ac_from_alu = 1'b1;
                  ctrl_o.alu_op      = (op_i == OP_AND) ? ALU_AND : ALU_ADD;
                end
              endcase
            end
            default: ;
          endcase
        end
        OP_JMP:  ctrl_o.pc_ld = 1'b1;
        OP_JZ:   ctrl_o.pc_ld = ac_zero_i;
        OP_CMPL: begin
          ctrl_o.alu_en      = 1'b1;
          ctrl_o.alu_opnd    = 1'b1;
          ctrl_o.ac_from_alu = 1'b1;
          ctrl_o.alu_op      = ALU_NOT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_ctrl_outreg.sv
module acc_ctrl_outreg
  import acc_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_d_i,
  output ctrl_t ctrl_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q_o <= CTRL_IDLE;
    else         ctrl_q_o <= ctrl_d_i;
  end

endmodule

// File: rtl/acc_ctrl_unit.sv
module acc_ctrl_unit
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned FETCH_STEPS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] opcode_i,
  input  logic       ac_zero_i,
  output logic       fetch_o,
  output logic       busy_o,
  output logic       mar_ld_o,
  output logic       mbr_from_mem_o,
  output logic       mem_rd_o,
  output logic       ac_from_mbr_o,
  output logic       mbr_from_ac_o,
  output logic       mem_from_mbr_o,
  output logic       mem_wr_o,
  output logic       pc_ld_o,
  output logic       alu_en_o,
  output logic       alu_opnd_o,
  output logic       ac_from_alu_o,
  output logic [1:0] alu_op_o,
  output logic       done_o,
  output logic       illegal_o
);

  phase_e            phase_d;
  logic [STEP_W-1:0] step_d;
  opcode_e           op_d;
  logic              done_d, illegal_d;
  ctrl_t             ctrl_d, ctrl_q;

  acc_ctrl_seq #(.FETCH_STEPS(FETCH_STEPS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .opcode_i    (opcode_i),
    .phase_d_o   (phase_d),
    .step_d_o    (step_d),
    .op_d_o      (op_d),
    .done_d_o    (done_d),
    .illegal_d_o (illegal_d)
  );

  acc_ctrl_decode u_dec (
    .phase_i   (phase_d),
    .step_i    (step_d),
    .op_i      (op_d),
    .ac_zero_i (ac_zero_i),
    .done_i    (done_d),
    .illegal_i (illegal_d),
    .ctrl_o    (ctrl_d)
  );

  acc_ctrl_outreg u_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_d_i (ctrl_d),
    .ctrl_q_o (ctrl_q)
  );

  assign fetch_o        = ctrl_q.fetch;
  assign busy_o         = ctrl_q.busy;
  assign mar_ld_o       = ctrl_q.mar_ld;
  assign mbr_from_mem_o = ctrl_q.mbr_from_mem;
  assign mem_rd_o       = ctrl_q.mem_rd;
  assign ac_from_mbr_o  = ctrl_q.ac_from_mbr;
  assign mbr_from_ac_o  = ctrl_q.mbr_from_ac;
  assign mem_from_mbr_o = ctrl_q.mem_from_mbr;
  assign mem_wr_o       = ctrl_q.mem_wr;
  assign pc_ld_o        = ctrl_q.pc_ld;
  assign alu_en_o       = ctrl_q.alu_en;
  assign alu_opnd_o     = ctrl_q.alu_opnd;
  assign ac_from_alu_o  = ctrl_q.ac_from_alu;
  assign alu_op_o       = ctrl_q.alu_op;
  assign done_o         = ctrl_q.done;
  assign illegal_o      = ctrl_q.illegal;

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R13

  AST_WB_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_from_alu_o |-> !(mar_ld_o || mbr_from_mem_o)); // R13

  AST_ALU_TRIPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_en_o |-> (alu_opnd_o && ac_from_alu_o)); // R9

  AST_ALU_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_en_o |-> (alu_op_o == 2'b11)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10

  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(busy_o || done_o || mar_ld_o || mem_rd_o || mem_wr_o ||
                    pc_ld_o || alu_en_o || mbr_from_ac_o)); // R11

  AST_FETCH_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> fetch_o); // R2

endmodule

// File: tb/acc_ctrl_unit_test.sv
module acc_ctrl_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] opcode = 3'd0;
  logic       ac_zero = 1'b0;

  logic fetch, busy, mar_ld, mbr_mem, mem_rd, ac_mbr, mbr_ac, mem_mbr, mem_wr;
  logic pc_ld, alu_en, alu_opnd, ac_alu, done, illegal;
  logic [1:0] alu_op;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  acc_ctrl_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .ac_zero_i(ac_zero), .fetch_o(fetch), .busy_o(busy), .mar_ld_o(mar_ld),
    .mbr_from_mem_o(mbr_mem), .mem_rd_o(mem_rd), .ac_from_mbr_o(ac_mbr),
    .mbr_from_ac_o(mbr_ac), .mem_from_mbr_o(mem_mbr), .mem_wr_o(mem_wr),
    .pc_ld_o(pc_ld), .alu_en_o(alu_en), .alu_opnd_o(alu_opnd),
    .ac_from_alu_o(ac_alu), .alu_op_o(alu_op), .done_o(done), .illegal_o(illegal)
  );

  localparam logic [16:0] M_FETCH = 17'b1 << 16;
  localparam logic [16:0] M_BUSY  = 17'b1 << 15;
  localparam logic [16:0] M_MAR   = 17'b1 << 14;
  localparam logic [16:0] M_MBRM  = 17'b1 << 13;
  localparam logic [16:0] M_RD    = 17'b1 << 12;
  localparam logic [16:0] M_ACMBR = 17'b1 << 11;
  localparam logic [16:0] M_MBRAC = 17'b1 << 10;
  localparam logic [16:0] M_MEMBR = 17'b1 << 9;
  localparam logic [16:0] M_WR    = 17'b1 << 8;
  localparam logic [16:0] M_PC    = 17'b1 << 7;
  localparam logic [16:0] M_ALU   = 17'b1 << 6;
  localparam logic [16:0] M_OPND  = 17'b1 << 5;
  localparam logic [16:0] M_ACALU = 17'b1 << 4;
  localparam logic [16:0] M_PASS  = 17'b11 << 2;
  localparam logic [16:0] M_DONE  = 17'b1 << 1;
  localparam logic [16:0] M_ILL   = 17'b1;
  localparam logic [16:0] V_IDLE  = M_PASS;
  localparam logic [16:0] V_FETCH = M_FETCH | M_BUSY | M_PASS;
  localparam logic [16:0] V_DONE  = M_DONE | M_PASS;

  function automatic logic [16:0] alu_vec(input logic [1:0] code);
    return M_BUSY | M_ALU | M_OPND | M_ACALU | (17'(code) << 2);
  endfunction

  function automatic logic [16:0] sample();
    return {fetch, busy, mar_ld, mbr_mem, mem_rd, ac_mbr, mbr_ac, mem_mbr,
            mem_wr, pc_ld, alu_en, alu_opnd, ac_alu, alu_op, done, illegal};
  endfunction

  task automatic check(input logic [16:0] exp, input string req, input string what);
    logic [16:0] got;
    got = sample();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive start at a falling edge; returns at the falling edge where fetch is visible
  task automatic issue(input logic [2:0] op);
    start  = 1'b1;
    opcode = op;
    @(negedge clk);
    start  = 1'b0;
    opcode = 3'd0;
  endtask

  task automatic t_reset();
    check(V_IDLE, "R1", "in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(V_IDLE, "R1", "after reset");
  endtask

  task automatic t_load();
    issue(3'd0);
    check(V_FETCH, "R2", "load fetch");
    @(negedge clk); check(M_BUSY | M_MAR | M_PASS, "R3", "load t1");
    @(negedge clk); check(M_BUSY | M_MBRM | M_RD | M_PASS, "R3", "load t2");
    @(negedge clk); check(M_BUSY | M_ACMBR | M_PASS, "R3", "load t3");
    @(negedge clk); check(V_DONE, "R10", "load done");
    @(negedge clk); check(V_IDLE, "R10", "load idle");
  endtask

  task automatic t_store();
    issue(3'd1);
    check(V_FETCH, "R2", "store fetch");
    // R12: start and opcode noise while busy
    start = 1'b1; opcode = 3'd4;
    @(negedge clk); check(M_BUSY | M_MAR | M_PASS, "R4", "store t1");
    opcode = 3'd7;
    @(negedge clk); check(M_BUSY | M_MBRAC | M_PASS, "R4", "store t2");
    opcode = 3'd6;
    @(negedge clk); check(M_BUSY | M_MEMBR | M_WR | M_PASS, "R4", "store t3");
    start = 1'b0; opcode = 3'd0;
    @(negedge clk); check(V_DONE, "R12", "store done unchanged");
    @(negedge clk); check(V_IDLE, "R12", "store idle after noise");
  endtask

  task automatic t_alu3(input logic [2:0] op, input logic [1:0] code, input string what);
    issue(op);
    check(V_FETCH, "R2", what);
    @(negedge clk); check(M_BUSY | M_MAR | M_PASS, "R5", what);
    @(negedge clk); check(M_BUSY | M_MBRM | M_RD | M_PASS, "R5", what);
    @(negedge clk); check(alu_vec(code), "R5", what);
    @(negedge clk); check(V_DONE, "R10", what);
    @(negedge clk); check(V_IDLE, "R9", what);
  endtask

  task automatic t_jump();
    issue(3'd4);
    check(V_FETCH, "R2", "jump fetch");
    @(negedge clk); check(M_BUSY | M_PC | M_PASS, "R6", "jump t1");
    @(negedge clk); check(V_DONE, "R10", "jump done");
    @(negedge clk); check(V_IDLE, "R10", "jump idle");
  endtask

  task automatic t_jz(input logic z);
    ac_zero = z;
    issue(3'd5);
    check(V_FETCH, "R2", "jz fetch");
    @(negedge clk);
    check(z ? (M_BUSY | M_PC | M_PASS) : (M_BUSY | M_PASS), "R7", z ? "jz taken" : "jz not taken");
    @(negedge clk); check(V_DONE, "R10", "jz done");
    @(negedge clk); check(V_IDLE, "R10", "jz idle");
    ac_zero = 1'b0;
  endtask

  task automatic t_cmpl();
    issue(3'd6);
    check(V_FETCH, "R2", "cmpl fetch");
    @(negedge clk); check(alu_vec(2'b10), "R8", "cmpl t1");
    @(negedge clk); check(V_DONE, "R10", "cmpl done");
    @(negedge clk); check(V_IDLE, "R9", "cmpl idle");
  endtask

  task automatic t_illegal();
    issue(3'd7);
    check(V_IDLE | M_ILL, "R11", "illegal pulse");
    @(negedge clk); check(V_IDLE, "R11", "illegal one cycle");
    @(negedge clk); check(V_IDLE, "R11", "still idle");
  endtask

  task automatic t_back_to_back();
    issue(3'd6);
    @(negedge clk); check(alu_vec(2'b10), "R8", "b2b cmpl t1");
    @(negedge clk); check(V_DONE, "R10", "b2b done");
    issue(3'd4);
    check(V_FETCH, "R10", "start in done cycle accepted");
    @(negedge clk); check(M_BUSY | M_PC | M_PASS, "R6", "b2b jump t1");
    @(negedge clk); check(V_DONE, "R10", "b2b jump done");
    @(negedge clk); check(V_IDLE, "R13", "b2b idle");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_alu3(3'd2, 2'b00, "add");
    t_alu3(3'd3, 2'b01, "and");
    t_jump();
    t_jz(1'b1);
    t_jz(1'b0);
    t_cmpl();
    t_illegal();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule